// File: doc/BRIEF.md
# Wide-to-Narrow Bus Subordinate Bridge

This bridge lets a narrow pipelined-bus subordinate sit on a wider pipelined bus. On the wide side it answers as a subordinate; on the narrow side it acts as the manager. The address-phase signals reach the narrow side combinationally, so a forwarded transfer gains no wait states. The bridge registers, at each address-phase hand-off, which narrow-width segment of the wide data bus the transfer uses. That segment is taken from the address bits just above the narrow byte offset.

Write data is taken from the chosen segment of the wide write bus. Read data returns in one of two ways, chosen by a parameter. It can be copied onto every segment, or placed only on the chosen segment with zeros elsewhere to save toggling power. A transfer larger than the narrow subordinate can take is never forwarded and is answered with a two-cycle ERROR.

Back-pressure works as on any pipelined bus. A low ready stretches the data phase. The manager keeps its write data steady until ready is high. The next address phase is only taken in a cycle where the bus-level ready input is high. Read data means something only in the completing cycle of an OKAY transfer.

Top module: `wide_to_narrow_bridge`

## Requirements
- R1: When the wide-side request is selected and its size code (bytes = 2^size) is at most log2(NARROW_W/8), the bridge passes select, transfer type, address, size and write flag to the narrow side in the same cycle. Transfer type codes: 0 idle, 1 busy, 2 non-sequential, 3 sequential.
- R2: A selected request whose size code exceeds log2(NARROW_W/8) reaches the narrow side with select low and transfer type idle (0).
- R3: After an oversized active request is accepted, the wide side sees ready low with response ERROR (1) for one cycle. In the next cycle it sees ready high with response ERROR.
- R4: Throughout a forwarded data phase, the narrow write data equals segment k of the wide write data, bits [k*NARROW_W +: NARROW_W]. Here k is address bits [log2(WIDE_W/8)-1 : log2(NARROW_W/8)] of the accepted address phase.
- R5: With READ_REPLICATE=1, the wide read data in a forwarded data phase is the narrow read data copied onto every segment.
- R6: With READ_REPLICATE=0, the wide read data in a forwarded data phase holds the narrow read data in segment k and zero in every other segment.
- R7: During a forwarded data phase, the wide-side ready output equals the narrow-side ready.
- R8: During a forwarded data phase, the narrow-side response, including ERROR, appears unchanged on the wide side.
- R9: Out of reset, and after an idle or unselected address phase, the wide side shows ready high, response OKAY (0) and read data zero.
- R10: The segment index is captured only when the bus ready input is high. Address and size changes during a stretched data phase do not move the write-data segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| up_sel | input | 1 | Wide-side subordinate select |
| up_addr | input | AW | Wide-side address |
| up_trans | input | 2 | Wide-side transfer type |
| up_write | input | 1 | Wide-side write flag |
| up_size | input | 3 | Wide-side size code |
| up_wdata | input | WIDE_W | Wide write data |
| up_ready_in | input | 1 | Bus-level ready seen by all subordinates |
| up_ready_out | output | 1 | Bridge ready to the wide bus |
| up_resp | output | 1 | Bridge response, 0 OKAY, 1 ERROR |
| up_rdata | output | WIDE_W | Wide read data |
| dn_sel | output | 1 | Narrow subordinate select |
| dn_addr | output | AW | Narrow address |
| dn_trans | output | 2 | Narrow transfer type |
| dn_write | output | 1 | Narrow write flag |
| dn_size | output | 3 | Narrow size code |
| dn_wdata | output | NARROW_W | Narrow write data |
| dn_ready_in | output | 1 | Bus ready passed to the narrow subordinate |
| dn_ready | input | 1 | Narrow subordinate ready |
| dn_resp | input | 1 | Narrow subordinate response |
| dn_rdata | input | NARROW_W | Narrow read data |

## Verification
The bench targets segment selection at both halves of the wide bus. A bridge that decodes the wrong address bit would swap halves or leak data into the zeroed half in power-saving mode. It moves the wide-side address during stretched data phases, so a segment register that is not gated by ready would route write data from the wrong half. Oversized sizes (doubleword and above) must yield the exact ready-low-then-high ERROR pair without a narrow select; a one-cycle or forwarded error would show up there. Downstream ERROR and wait states must pass through cycle for cycle.

// File: rtl/w2n_pkg.sv
package w2n_pkg;
  typedef enum logic [1:0] {
    DP_IDLE = 2'd0,
    DP_FWD  = 2'd1,
    DP_ERR1 = 2'd2,
    DP_ERR2 = 2'd3
  } dp_state_t;

  localparam logic [1:0] TRANS_IDLE = 2'b00;
  localparam logic       RESP_OKAY  = 1'b0;
  localparam logic       RESP_ERROR = 1'b1;
endpackage

// File: rtl/w2n_dphase_ctrl.sv
module w2n_dphase_ctrl
  import w2n_pkg::*;
#(
  parameter int SEG_BITS = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ready_in,
  input  logic                req_active,
  input  logic                req_oversize,
  input  logic [SEG_BITS-1:0] seg_in,
  input  logic                dn_ready,
  input  logic                dn_resp,
  output logic [SEG_BITS-1:0] seg_q,
  output logic                fwd,
  output logic                ready_out,
  output logic                resp_out
);
  dp_state_t state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DP_IDLE;
      seg_q   <= '0;
    end else if (state_q == DP_ERR1) begin
      state_q <= DP_ERR2;
    end else if (ready_in) begin
      seg_q <= seg_in;
      if (!req_active)       state_q <= DP_IDLE;
      else if (req_oversize) state_q <= DP_ERR1;
      else                   state_q <= DP_FWD;
    end
  end

  always_comb begin
    fwd       = 1'b0;
    ready_out = 1'b1;
    resp_out  = RESP_OKAY;
    unique case (state_q)
      DP_FWD: begin
        fwd       = 1'b1;
        ready_out = dn_ready;
        resp_out  = dn_resp;
      end
      DP_ERR1: begin
        ready_out = 1'b0;
        resp_out  = RESP_ERROR;
      end
      DP_ERR2: resp_out = RESP_ERROR;
      default: ;
    endcase
  end

  assert_err_second_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == DP_ERR1) |=> (ready_out && resp_out == RESP_ERROR));

  assert_ready_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fwd |-> (ready_out == dn_ready && resp_out == dn_resp));

  assert_idle_okay_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_in && !req_active) |=> (ready_out && resp_out == RESP_OKAY));

  assert_seg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_in |=> $stable(seg_q));
endmodule

// File: rtl/w2n_wr_select.sv
module w2n_wr_select #(
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32,
  parameter int SEG_BITS = 1
) (
  input  logic [WIDE_W-1:0]   wide_in,
  input  logic [SEG_BITS-1:0] seg,
  output logic [NARROW_W-1:0] narrow_out
);
  localparam int NSEG = WIDE_W / NARROW_W;

  logic [NARROW_W-1:0] parts [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_part
    assign parts[g] = wide_in[g*NARROW_W +: NARROW_W];
  end

  assign narrow_out = parts[seg];
endmodule

// File: rtl/w2n_rd_steer.sv
module w2n_rd_steer #(
  parameter int WIDE_W         = 64,
  parameter int NARROW_W       = 32,
  parameter int SEG_BITS       = 1,
  parameter bit READ_REPLICATE = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fwd,
  input  logic [SEG_BITS-1:0] seg,
  input  logic [NARROW_W-1:0] narrow_in,
  output logic [WIDE_W-1:0]   wide_out
);
  localparam int NSEG = WIDE_W / NARROW_W;

  for (genvar g = 0; g < NSEG; g++) begin : g_lane
    if (READ_REPLICATE) begin : g_copy
      assign wide_out[g*NARROW_W +: NARROW_W] = fwd ? narrow_in : '0;
    end else begin : g_quiet
      assign wide_out[g*NARROW_W +: NARROW_W] =
        (fwd && seg == SEG_BITS'(g)) ? narrow_in : '0;

      assert_quiet_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seg != SEG_BITS'(g)) |-> (wide_out[g*NARROW_W +: NARROW_W] == '0));
    end
  end
endmodule

// File: rtl/wide_to_narrow_bridge.sv
module wide_to_narrow_bridge
  import w2n_pkg::*;
#(
  parameter int AW             = 32,
  parameter int WIDE_W         = 64,
  parameter int NARROW_W       = 32,
  parameter bit READ_REPLICATE = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                up_sel,
  input  logic [AW-1:0]       up_addr,
  input  logic [1:0]          up_trans,
  input  logic                up_write,
  input  logic [2:0]          up_size,
  input  logic [WIDE_W-1:0]   up_wdata,
  input  logic                up_ready_in,
  output logic                up_ready_out,
  output logic                up_resp,
  output logic [WIDE_W-1:0]   up_rdata,
  output logic                dn_sel,
  output logic [AW-1:0]       dn_addr,
  output logic [1:0]          dn_trans,
  output logic                dn_write,
  output logic [2:0]          dn_size,
  output logic [NARROW_W-1:0] dn_wdata,
  output logic                dn_ready_in,
  input  logic                dn_ready,
  input  logic                dn_resp,
  input  logic [NARROW_W-1:0] dn_rdata
);
  localparam int NB_BITS  = $clog2(NARROW_W / 8);
  localparam int WB_BITS  = $clog2(WIDE_W / 8);
  localparam int SEG_BITS = WB_BITS - NB_BITS;

  logic                oversize;
  logic                req_active;
  logic [SEG_BITS-1:0] seg_in;
  logic [SEG_BITS-1:0] seg_q;
  logic                fwd;

  assign oversize   = up_size > 3'(NB_BITS);
  assign req_active = up_sel && up_trans[1];
  assign seg_in     = up_addr[WB_BITS-1:NB_BITS];

  assign dn_sel      = up_sel && !oversize;
  assign dn_trans    = dn_sel ? up_trans : TRANS_IDLE;
  assign dn_addr     = up_addr;
  assign dn_write    = up_write;
  assign dn_size     = up_size;
  assign dn_ready_in = up_ready_in;

  w2n_dphase_ctrl #(.SEG_BITS(SEG_BITS)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .ready_in     (up_ready_in),
    .req_active   (req_active),
    .req_oversize (oversize),
    .seg_in       (seg_in),
    .dn_ready     (dn_ready),
    .dn_resp      (dn_resp),
    .seg_q        (seg_q),
    .fwd          (fwd),
    .ready_out    (up_ready_out),
    .resp_out     (up_resp)
  );

  w2n_wr_select #(
    .WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .SEG_BITS(SEG_BITS)
  ) u_wr (
    .wide_in    (up_wdata),
    .seg        (seg_q),
    .narrow_out (dn_wdata)
  );

  w2n_rd_steer #(
    .WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .SEG_BITS(SEG_BITS),
    .READ_REPLICATE(READ_REPLICATE)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .fwd       (fwd),
    .seg       (seg_q),
    .narrow_in (dn_rdata),
    .wide_out  (up_rdata)
  );

  assert_oversize_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (up_ready_in && req_active && oversize) |=> (!up_ready_out && up_resp == RESP_ERROR));

  assert_oversize_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (up_sel && oversize) |-> (dn_trans == TRANS_IDLE));
endmodule

// File: tb/wide_to_narrow_bridge_test.sv
`timescale 1ns/1ps
module wide_to_narrow_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        up_sel = 1'b0;
  logic [31:0] up_addr = '0;
  logic [1:0]  up_trans = 2'b00;
  logic        up_write = 1'b0;
  logic [2:0]  up_size = 3'd0;
  logic [63:0] up_wdata = '0;
  logic        up_ready_in;
  logic        up_ready_out, up_resp;
  logic [63:0] up_rdata;
  logic        dn_sel, dn_write, dn_ready_in;
  logic [31:0] dn_addr, dn_wdata;
  logic [1:0]  dn_trans;
  logic [2:0]  dn_size;
  logic        dn_ready = 1'b1;
  logic        dn_resp = 1'b0;
  logic [31:0] dn_rdata = '0;

  logic        q_ready_out, q_resp, q_sel, q_write, q_ready_in;
  logic [63:0] q_rdata;
  logic [31:0] q_addr, q_wdata;
  logic [1:0]  q_trans;
  logic [2:0]  q_size;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;
  assign up_ready_in = up_ready_out;

  wide_to_narrow_bridge #(.READ_REPLICATE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .up_sel(up_sel), .up_addr(up_addr),
    .up_trans(up_trans), .up_write(up_write), .up_size(up_size),
    .up_wdata(up_wdata), .up_ready_in(up_ready_in),
    .up_ready_out(up_ready_out), .up_resp(up_resp), .up_rdata(up_rdata),
    .dn_sel(dn_sel), .dn_addr(dn_addr), .dn_trans(dn_trans),
    .dn_write(dn_write), .dn_size(dn_size), .dn_wdata(dn_wdata),
    .dn_ready_in(dn_ready_in), .dn_ready(dn_ready), .dn_resp(dn_resp),
    .dn_rdata(dn_rdata)
  );

  wide_to_narrow_bridge #(.READ_REPLICATE(1'b0)) uut_quiet (
    .clk(clk), .rst_n(rst_n), .up_sel(up_sel), .up_addr(up_addr),
    .up_trans(up_trans), .up_write(up_write), .up_size(up_size),
    .up_wdata(up_wdata), .up_ready_in(up_ready_in),
    .up_ready_out(q_ready_out), .up_resp(q_resp), .up_rdata(q_rdata),
    .dn_sel(q_sel), .dn_addr(q_addr), .dn_trans(q_trans),
    .dn_write(q_write), .dn_size(q_size), .dn_wdata(q_wdata),
    .dn_ready_in(q_ready_in), .dn_ready(dn_ready), .dn_resp(dn_resp),
    .dn_rdata(dn_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_copy(input logic [31:0] rd);
    return {rd, rd};
  endfunction

  function automatic logic [63:0] exp_quiet(input logic [31:0] rd, input int seg);
    return (seg == 1) ? {rd, 32'h0} : {32'h0, rd};
  endfunction

  function automatic logic [31:0] exp_wseg(input logic [63:0] wd, input int seg);
    return (seg == 1) ? wd[63:32] : wd[31:0];
  endfunction

  task automatic xfer(input logic [31:0] a, input logic [2:0] sz, input logic wr,
                      input logic [63:0] wd, input int waits, input logic [31:0] rd,
                      input logic derr);
    bit over;
    int seg;
    over = (sz > 3'd2);
    seg  = int'(a[2]);
    @(negedge clk);
    up_sel = 1'b1; up_trans = 2'b10; up_addr = a; up_size = sz; up_write = wr;
    dn_ready = 1'b1; dn_resp = 1'b0;
    #1;
    if (over)
      chk(dn_sel == 1'b0 && dn_trans == 2'b00, "R2", {62'h0, dn_trans}, 64'h0);
    else
      chk(dn_sel && dn_trans == 2'b10 && dn_addr == a && dn_size == sz && dn_write == wr,
          "R1", {32'h0, dn_addr}, {32'h0, a});
    @(negedge clk);
    // R10: wide-side address wanders during the data phase
    up_sel = 1'b0; up_trans = 2'b00; up_addr = $urandom; up_size = 3'($urandom);
    up_wdata = wd;
    if (over) begin
      #1;
      chk(!up_ready_out && up_resp, "R3", {62'h0, up_ready_out, up_resp}, 64'h1);
      @(negedge clk);
      #1;
      chk(up_ready_out && up_resp, "R3", {62'h0, up_ready_out, up_resp}, 64'h3);
    end else begin
      for (int i = 0; i < waits; i++) begin
        dn_ready = 1'b0;
        dn_resp = derr && (i == waits - 1);
        dn_rdata = $urandom;
        #1;
        chk(up_ready_out == 1'b0, "R7", {63'h0, up_ready_out}, 64'h0);
        chk(up_resp == dn_resp, "R8", {63'h0, up_resp}, {63'h0, dn_resp});
        if (wr) chk(dn_wdata == exp_wseg(wd, seg), "R4 R10", {32'h0, dn_wdata},
                    {32'h0, exp_wseg(wd, seg)});
        @(negedge clk);
        up_addr = $urandom; up_size = 3'($urandom);
      end
      dn_ready = 1'b1; dn_resp = derr; dn_rdata = rd;
      #1;
      chk(up_ready_out == 1'b1, "R7", {63'h0, up_ready_out}, 64'h1);
      chk(up_resp == derr, "R8", {63'h0, up_resp}, {63'h0, derr});
      if (wr) chk(dn_wdata == exp_wseg(wd, seg), "R4", {32'h0, dn_wdata},
                  {32'h0, exp_wseg(wd, seg)});
      if (!wr && !derr) begin
        chk(up_rdata == exp_copy(rd), "R5", up_rdata, exp_copy(rd));
        chk(q_rdata == exp_quiet(rd, seg), "R6", q_rdata, exp_quiet(rd, seg));
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(up_ready_out && !up_resp && up_rdata == 64'h0, "R9 reset",
        {62'h0, up_ready_out, up_resp}, 64'h2);
    // idle transfer while selected
    @(negedge clk);
    up_sel = 1'b1; up_trans = 2'b00; up_size = 3'd2; up_addr = 32'h1004;
    @(negedge clk);
    up_sel = 1'b0;
    #1;
    chk(up_ready_out && !up_resp && up_rdata == 64'h0 && q_rdata == 64'h0, "R9 idle",
        {62'h0, up_ready_out, up_resp}, 64'h2);

    // directed corners
    xfer(32'h1000, 3'd2, 1'b0, 64'h0, 0, 32'h1122_3344, 1'b0);
    xfer(32'h1004, 3'd2, 1'b0, 64'h0, 2, 32'hA5A5_0F0F, 1'b0);
    xfer(32'h1002, 3'd0, 1'b1, 64'h8877_6655_4433_2211, 3, 32'h0, 1'b0);
    xfer(32'h1006, 3'd1, 1'b1, 64'hDEAD_BEEF_CAFE_F00D, 0, 32'h0, 1'b0);
    xfer(32'h1000, 3'd3, 1'b0, 64'h0, 0, 32'h0, 1'b0);
    xfer(32'h1008, 3'd4, 1'b1, 64'h1, 0, 32'h0, 1'b0);
    xfer(32'h100C, 3'd2, 1'b0, 64'h0, 1, 32'h0BAD_0BAD, 1'b1);
    xfer(32'h1004, 3'd2, 1'b1, 64'h0123_4567_89AB_CDEF, 1, 32'h0, 1'b1);

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [2:0] sz;
      logic [31:0] a;
      int w;
      logic e;
      sz = 3'($urandom_range(0, 4));
      a  = $urandom & ~((32'h1 << sz) - 32'h1);
      w  = $urandom_range(0, 3);
      e  = ($urandom_range(0, 7) == 0);
      if (e && w == 0) w = 1;
      xfer(a, sz, 1'($urandom), {$urandom, $urandom}, w, $urandom, e);
    end

    @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule